// File: doc/BRIEF.md
# External Interrupt Source Multiplexer

This block steers general-purpose pin levels onto a fixed set of external-interrupt lines. All pins of all ports arrive as one flat vector. Each port owns a contiguous group of sixteen bits, so the input with index k belongs to port k/16 and is pin k%16 of that port. Line n can only ever be driven by pin n of some port. A 4-bit selection code per line chooses the port.

The selection codes live in four 32-bit selection registers, four codes per register, loaded through a small write port. Only the low sixteen bits of each register hold codes. The upper bits of a write are discarded. After reset every code is zero, so port 0 drives every line. A code that names a port beyond the last one holds its line low.

Line outputs are registered levels meant for a downstream interrupt controller, which does its own edge detection, masking and pending logic. A pin change shows on its line one clock later. A new selection, loaded on a clock edge, shows on the following edge.

Top module: `ext_route_mux`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every line output is 0. After reset, every selection code is 0, so line n follows pin n of port 0 (input index n).
- R2: Line n is driven only by input index p*16+n, where p is the port chosen by the line's code. For example, index 16 is port 1, pin 0, and can only reach line 0.
- R3: The code for line n sits in selection register n/4, at bits 4*(n%4)+3 down to 4*(n%4). Writing 0x10 to register 0 routes port 1, pin 1 onto line 1. Writing 0x1 to register 0 routes port 1, pin 0 onto line 0.
- R4: Line outputs are registered. A pin change applied between clock edges appears on its line after the next rising edge and not before it.
- R5: A selection code of 8 or more (there are 8 ports) drives its line to 0, whatever the input levels are.
- R6: Once a line is routed to a port, the same pin on any other port has no effect on it. A pin raised on one port affects only the line of that pin number: pin 0 high leaves line 2 low, and pin 2 high leaves line 0 low.
- R7: A write with `cfg_we`=1 replaces register `cfg_idx` with `cfg_wdata[15:0]`. Bits 31:16 are ignored, and the other registers are unchanged.
- R8: A selection loaded on a rising edge changes the lines from the next rising edge onward. On the edge that loads it, the old selection still applies.
- R9: Reset returns every selection code to 0, even after earlier writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a selection register |
| cfg_idx | input | 2 | Selection register number for the write |
| cfg_wdata | input | 32 | Write data; bits 15:0 hold four 4-bit codes |
| pin_in | input | 128 | Pin levels, index = port*16 + pin |
| line_out | output | 16 | Registered interrupt line levels |

## Verification
A corrupted selection code shows up as a line that tracks a pin of the wrong port, or sits at 0. The first stimulus that separates two ports on that pin number exposes it, one edge after the pins are driven. A code stored at the wrong field position appears on a neighbouring line. A lost or late write shows up as the old routing persisting beyond the second edge after the write. The table covers each register and the out-of-range codes. Every comparison is on the full 16-bit line vector, so a stray assertion on any other line is caught in the same cycle.

// File: rtl/ext_route_pkg.sv
// Package: ext_route_pkg
// Shared sizing for the external interrupt source multiplexer.
// Assumes one selection field per line and whole fields per register.
package ext_route_pkg;
    localparam int LINES          = 16;
    localparam int PORTS          = 8;
    localparam int SEL_W          = 4;
    localparam int REG_W          = 32;
    localparam int FIELDS_PER_REG = 4;
    localparam int NUM_REGS       = LINES / FIELDS_PER_REG;

    typedef logic [SEL_W-1:0] sel_code_t;
endpackage

// File: rtl/ext_route_selbank.sv
// Module: ext_route_selbank
// Holds the per-line selection codes in NUM_REGS registers of FIELDS codes
// each. A write stores the low FIELDS*SEL_W bits of the data into the
// addressed register. Higher data bits are discarded.
// Assumes DATA_W >= FIELDS*SEL_W and a synchronous active-low reset.
module ext_route_selbank #(
    parameter int NUM_REGS = 4,
    parameter int FIELDS   = 4,
    parameter int SEL_W    = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [IDX_W-1:0]                 cfg_idx,
    input  logic [DATA_W-1:0]                cfg_wdata,
    output logic [NUM_REGS*FIELDS*SEL_W-1:0] sel_flat
);
    localparam int FLD_BITS = FIELDS * SEL_W;

    genvar r;
    generate
        for (r = 0; r < NUM_REGS; r++) begin : g_reg
            logic [FLD_BITS-1:0] fld_q;

            // Load this register's codes on a write addressed to it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fld_q <= '0;
                else if (cfg_we && (int'(cfg_idx) == r))
                    fld_q <= cfg_wdata[FLD_BITS-1:0];
            end

            assign sel_flat[r*FLD_BITS +: FLD_BITS] = fld_q;

            // R7: an addressed write lands with upper data bits dropped
            a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && (int'(cfg_idx) == r)) |=> (fld_q == $past(cfg_wdata[FLD_BITS-1:0])));
        end

        if (DATA_W > FLD_BITS) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^cfg_wdata[DATA_W-1:FLD_BITS];
        end
    endgenerate

    // R7, R8: without a write no code moves
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(sel_flat));

    // R9: the first cycle out of reset sees all codes cleared
    a_r9_codes_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel_flat == '0));
endmodule

// File: rtl/ext_route_lane.sv
// Module: ext_route_lane
// One interrupt line: picks one of NUM_PORTS candidate pins by its code
// and registers the result. Codes at or above NUM_PORTS give 0.
// Assumes NUM_PORTS <= 2**SEL_W.
module ext_route_lane #(
    parameter int NUM_PORTS = 8,
    parameter int SEL_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] cand,
    input  logic [SEL_W-1:0]     sel,
    output logic                 line_q
);
    localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic in_range;
    logic pick_d;

    // Decide whether the code names an existing port.
    always_comb in_range = (int'(sel) < NUM_PORTS);

    // Choose the candidate pin, or 0 for an unknown port.
    always_comb pick_d = in_range ? cand[sel[PIDX_W-1:0]] : 1'b0;

    // Register the chosen level for the interrupt controller.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= 1'b0;
        else
            line_q <= pick_d;
    end

    // R5: an out-of-range code yields a low line one cycle later
    a_r5_out_of_range_low: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) >= NUM_PORTS) |=> (line_q == 1'b0));

    // R4, R2: a valid code makes the line copy that port's pin a cycle later
    a_r4_follows_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) < NUM_PORTS) |=> (line_q == $past(cand[sel[PIDX_W-1:0]])));
endmodule

// File: rtl/ext_route_mux.sv
// Module: ext_route_mux
// Top level: routes pin n of a selectable port onto interrupt line n.
// Inputs are flat, index = port*NUM_LINES + pin. Codes come from the
// selection bank, line n using bits n*SEL_W of the concatenated registers.
// Assumes a synchronous active-low reset.
module ext_route_mux #(
    parameter int NUM_LINES      = ext_route_pkg::LINES,
    parameter int NUM_PORTS      = ext_route_pkg::PORTS,
    parameter int SEL_W          = ext_route_pkg::SEL_W,
    parameter int REG_W          = ext_route_pkg::REG_W,
    parameter int FIELDS_PER_REG = ext_route_pkg::FIELDS_PER_REG
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [1:0]                     cfg_idx,
    input  logic [REG_W-1:0]               cfg_wdata,
    input  logic [NUM_PORTS*NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0]           line_out
);
    localparam int NUM_REGS = NUM_LINES / FIELDS_PER_REG;
    localparam int SEL_BITS = NUM_REGS * FIELDS_PER_REG * SEL_W;

    logic [SEL_BITS-1:0] sel_flat;

    ext_route_selbank #(
        .NUM_REGS (NUM_REGS),
        .FIELDS   (FIELDS_PER_REG),
        .SEL_W    (SEL_W),
        .DATA_W   (REG_W),
        .IDX_W    (2)
    ) u_selbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .sel_flat  (sel_flat)
    );

    genvar n, p;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_line
            logic [NUM_PORTS-1:0] cand;

            for (p = 0; p < NUM_PORTS; p++) begin : g_port
                assign cand[p] = pin_in[p*NUM_LINES + n];
            end

            ext_route_lane #(
                .NUM_PORTS (NUM_PORTS),
                .SEL_W     (SEL_W)
            ) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .cand   (cand),
                .sel    (sel_flat[n*SEL_W +: SEL_W]),
                .line_q (line_out[n])
            );
        end
    endgenerate

    // R1: lines are low on the first cycle out of reset
    a_r1_lines_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (line_out == '0));
endmodule

// File: tb/tb_ext_route_mux.sv
module tb_ext_route_mux;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]   idx;
        logic [31:0]  data;
        logic [127:0] pins;
        logic [15:0]  exp;
    } vec_t;

    // Cumulative: each row writes one register, drives pins, expects lines.
    localparam vec_t VECS [13] = '{
        '{2'd0, 32'h0000_0000, 128'h1,      16'h0001}, // R1 R2 port0 pin0
        '{2'd0, 32'h0000_0000, 128'h8000,   16'h8000}, // R1 port0 pin15
        '{2'd0, 32'h0000_0010, 128'h2_0000, 16'h0002}, // R3 port1 pin1 -> line1
        '{2'd0, 32'h0000_0010, 128'h1_0000, 16'h0000}, // R2 R6 port1 pin0, line0 on port0
        '{2'd0, 32'h0000_0001, 128'h1,      16'h0000}, // R3 R6 line0 on port1, port0 pin0 ignored
        '{2'd0, 32'h0000_0001, 128'h1_0000, 16'h0001}, // R3 port1 pin0 -> line0
        '{2'd3, 32'h0000_7000, 128'h80000000_00000000_00000000_00000000, 16'h8000}, // R3 line15 port7
        '{2'd3, 32'h0000_7000, 128'h8000,   16'h0000}, // R6 port0 pin15 ignored
        '{2'd1, 32'h0000_0300, 128'h0040_0000_0000_0004, 16'h0044}, // R3 line6 port3, line2 port0
        '{2'd2, 32'h0000_00F0, 128'h300,    16'h0100}, // R5 code 15 on line9
        '{2'd2, 32'h0000_0080, {128{1'b1}}, 16'hFDFF}, // R5 code 8 on line9
        '{2'd0, 32'hFFFF_0000, 128'h1_0000, 16'h0000}, // R7 upper bits dropped
        '{2'd0, 32'hFFFF_0000, 128'hFFFF,   16'h7DBF}  // R7 other registers kept
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_idx = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [127:0] pin_in = '0;
    logic [15:0]  line_out;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    ext_route_mux dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .pin_in    (pin_in),
        .line_out  (line_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: line_out=%h expected %h", tag, got, exp);
        end
    endtask

    // Drive a write at a falling edge; return at the falling edge after the loading edge.
    task automatic write_reg(input logic [1:0] idx, input logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_idx   = idx;
        cfg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: line_out=%h expected run end", line_out);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        pin_in = {128{1'b1}};
        repeat (3) @(negedge clk);
        check("R1 lines low in reset", line_out, 16'h0000);

        rst_n  = 1'b1;
        pin_in = 128'hFFFF;
        settle();
        check("R1 default routes port0", line_out, 16'hFFFF);
        pin_in = 128'hFFFF_0000;
        settle();
        check("R1 R6 port1 ignored by default", line_out, 16'h0000);

        // Table walk (R2 R3 R5 R6 R7)
        for (int i = 0; i < 13; i++) begin
            write_reg(VECS[i].idx, VECS[i].data);
            pin_in = VECS[i].pins;
            settle();
            check($sformatf("table row %0d (R2 R3 R5 R6 R7)", i), line_out, VECS[i].exp);
        end

        // R4: one-cycle latency from pin to line
        pin_in = '0;
        settle();
        pin_in = 128'h8;
        #(CLK_PERIOD/2 - 1);
        check("R4 before edge", line_out, 16'h0000);
        @(negedge clk);
        check("R4 after edge", line_out, 16'h0008);

        // R8: selection change takes effect on the edge after loading
        pin_in = 128'h8_0000;
        settle();
        check("R8 old route port0 line3", line_out, 16'h0000);
        write_reg(2'd0, 32'h0000_1000);
        check("R8 loading edge keeps old route", line_out, 16'h0000);
        settle();
        check("R8 new route port1 line3", line_out, 16'h0008);

        // R6: a pin touches only its own line
        write_reg(2'd0, 32'h0);
        pin_in = 128'h1;
        settle();
        check("R6 pin0 leaves line2 low", line_out, 16'h0001);
        pin_in = 128'h4;
        settle();
        check("R6 pin2 leaves line0 low", line_out, 16'h0004);

        // R9: reset clears earlier selections (line0 would need port1 if kept)
        write_reg(2'd0, 32'h0000_0001);
        rst_n = 1'b0;
        settle();
        check("R9 R1 low during reset", line_out, 16'h0000);
        rst_n  = 1'b1;
        pin_in = 128'h1_8000;
        settle();
        check("R9 codes back to port0", line_out, 16'h8000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule